// File: doc/BRIEF.md
# Register Scrub Sequencer for Secure/Non-secure Transitions

This block guards a banked register file whenever execution crosses between the secure and the non-secure state. It accepts one of four commands: a secure-side call into non-secure code, a non-secure interrupt that arrives while secure code runs, a secure function returning to a non-secure caller, and the resume that follows the interrupt handler. For each command it runs a fixed save-then-clear sequence. The save step pushes words onto the secure stack through a memory request port. The clear step zeroes the registers that could leak secure data and, on a call, plants a reserved return marker in the link register.

The command input is a valid/ready stream. `cmd_ready` is high only while the sequencer is idle, and a command is taken on a cycle where both `cmd_valid` and `cmd_ready` are high. The memory request port is also valid/ready. Once `mem_valid` is raised, the address, data and direction hold steady until `mem_ready` is seen high, and one word moves per accepted cycle. Read data returns on `rsp_valid`/`rsp_data` at any later cycle. The sequencer is always able to take that response, so that path has no ready.

The register file (r0..r15 plus a status word) lives inside the block. Software-side writes arrive on a plain port that is honoured only while idle. The secure stack pointer is kept by the block and checked against `stk_limit` before every push.

Top module: `world_scrub_seq`

## Requirements
- R1: `cmd_ready` is 1 only in idle. An accepted command makes `busy` 1 from the next cycle until the sequence ends. The sequence ends with exactly one cycle of `done` (with `busy` 0), after which `cmd_ready` returns to 1. Op encoding on `cmd_op`: 0 = call, 1 = interrupt, 2 = return, 3 = resume.
- R2: A call (op 0) pushes two words. The first is `cmd_ret_addr`, written at SP-4. The second is status & `PSR_KEEP`, written at SP-8. The final SP is the start value minus 8.
- R3: After a successful call, registers from n up to r12 are zero, where n is `cmd_nargs` clamped to 4. r0..r(n-1) are unchanged, the status word is zero, and r14 holds `RET_MARK`.
- R4: An interrupt (op 1) pushes 16 words at descending addresses in this order: status, r14, r12, r11 down to r0, and finally `SIG_WORD`. SP drops by 64.
- R5: After a successful interrupt push, r0..r12 and the status word are zero, and r14, r13 and r15 are unchanged.
- R6: A return (op 2) makes no memory request and leaves SP unchanged. It zeroes registers n up to r12 (n clamped as in R3) and the status word. Other registers are kept.
- R7: Before each push, if SP < 4 or SP-4 < `stk_limit`, no request is issued. The sequence ends with `done` and `fault` both 1. No register is cleared, and SP keeps the value after the last accepted push.
- R8: A resume (op 3) reads SP first and compares that word with `SIG_WORD`. It then reads upward one word per request to restore r0..r12, then r14, then the status word. SP rises by 64.
- R9: If the first word read by a resume differs from `SIG_WORD`, the sequence ends with `fault`. No register changes and SP is unchanged.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, the request (address, data, direction) holds steady into the next cycle.
- R11: Writes on the software register port and stack-pointer loads are ignored while a sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_op | input | 2 | Transition type |
| cmd_nargs | input | 3 | Argument/result register count (clamped to 4) |
| cmd_ret_addr | input | W | Return address pushed on a call |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fault | output | 1 | Valid with done: stack limit or signature failure |
| cpu_we | input | 1 | Register write from software side |
| cpu_idx | input | IW | Register index for that write |
| cpu_wdata | input | W | Register write data |
| cpu_psr_we | input | 1 | Status word write |
| cpu_psr_wdata | input | W | Status word data |
| sp_load | input | 1 | Load secure stack pointer |
| sp_wdata | input | W | New stack pointer value |
| stk_limit | input | W | Lowest legal stack address |
| rd_idx | input | IW | Register read index |
| rd_data | output | W | Register read data |
| psr_out | output | W | Current status word |
| sp_out | output | W | Current secure stack pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | W | Byte address of request |
| mem_wdata | output | W | Write data |
| rsp_valid | input | 1 | Read data returned |
| rsp_data | input | W | Read data |

## Verification
The bench builds the block with W = 32 and 16 registers, and passes `SIG_WORD`, `RET_MARK` and `PSR_KEEP` explicitly so that its own model holds the same constants. It places the stack pointer a few words above `stk_limit`, so a fault strikes after the first word of a call and partway through an interrupt push. An argument count above four exercises the clamp. The bench overwrites the stored signature word before a resume to trigger the mismatch path. Ready is throttled by a pseudo-random pattern throughout, which holds requests across stalled cycles.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef enum logic [1:0] {
    OP_CALL   = 2'd0,
    OP_IRQ    = 2'd1,
    OP_RET    = 2'd2,
    OP_RESUME = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_SCRUB, ST_POP_REQ, ST_POP_WAIT, ST_DONE
  } st_e;

  localparam int LR_IDX     = 14;  // link register receiving the marker
  localparam int SCRUB_TOP  = 12;  // highest general register cleared
  localparam int ARG_MAX    = 4;   // r0..r3 may carry arguments/results
  localparam int CALL_LAST  = 1;   // index of last word pushed on a call
  localparam int FRAME_LAST = 15;  // index of last word in an interrupt frame
endpackage

// File: rtl/wss_regbank.sv
module wss_regbank #(
  parameter int W     = 32,
  parameter int NREGS = 16,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_we,
  input  logic [IW-1:0]             cpu_idx,
  input  logic [W-1:0]              cpu_wdata,
  input  logic                      cpu_psr_we,
  input  logic [W-1:0]              cpu_psr_wdata,
  input  logic                      scrub_en,
  input  logic [NREGS-1:0]          scrub_mask,
  input  logic                      psr_clr,
  input  logic                      lr_load,
  input  logic [W-1:0]              lr_value,
  input  logic                      pop_we,
  input  logic [IW-1:0]             pop_idx,
  input  logic                      pop_psr_we,
  input  logic [W-1:0]              pop_data,
  output logic [NREGS-1:0][W-1:0]   regs_o,
  output logic [W-1:0]              psr_o
);
  import wss_pkg::*;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs_o[g] <= '0;
      else if (scrub_en && scrub_mask[g])      regs_o[g] <= '0;
      else if (lr_load && g == LR_IDX)         regs_o[g] <= lr_value;
      else if (pop_we && pop_idx == IW'(g))    regs_o[g] <= pop_data;
      else if (cpu_we && cpu_idx == IW'(g))    regs_o[g] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          psr_o <= '0;
    else if (psr_clr)    psr_o <= '0;
    else if (pop_psr_we) psr_o <= pop_data;
    else if (cpu_psr_we) psr_o <= cpu_psr_wdata;
  end

  // R11
  sw_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we || cpu_psr_we) |-> !(scrub_en || pop_we || pop_psr_we || lr_load || psr_clr));
endmodule

// File: rtl/wss_stack_ptr.sv
module wss_stack_ptr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] push_addr,
  output logic         push_below
);
  localparam logic [W-1:0] WORD = W'(4);

  assign push_addr  = sp_o - WORD;
  assign push_below = (sp_o < WORD) || (push_addr < limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp_o <= '0;
    else if (dec)  sp_o <= push_addr;
    else if (inc)  sp_o <= sp_o + WORD;
    else if (load) sp_o <= load_val;
  end

  // R7
  no_dec_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp_o >= limit);
  // R8
  inc_dec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));
endmodule

// File: rtl/world_scrub_seq.sv
module world_scrub_seq #(
  parameter int           W        = 32,
  parameter int           NREGS    = 16,
  parameter logic [W-1:0] SIG_WORD = 32'h5A17_C3E9,
  parameter logic [W-1:0] RET_MARK = 32'hFEFF_FFFE,
  parameter logic [W-1:0] PSR_KEEP = 32'h0000_01FF,
  localparam int          IW       = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [2:0]    cmd_nargs,
  input  logic [W-1:0]  cmd_ret_addr,
  output logic          busy,
  output logic          done,
  output logic          fault,
  input  logic          cpu_we,
  input  logic [IW-1:0] cpu_idx,
  input  logic [W-1:0]  cpu_wdata,
  input  logic          cpu_psr_we,
  input  logic [W-1:0]  cpu_psr_wdata,
  input  logic          sp_load,
  input  logic [W-1:0]  sp_wdata,
  input  logic [W-1:0]  stk_limit,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  psr_out,
  output logic [W-1:0]  sp_out,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          rsp_valid,
  input  logic [W-1:0]  rsp_data
);
  import wss_pkg::*;

  st_e               st;
  op_e               op_q;
  logic [2:0]        nargs_q;
  logic [4:0]        k;
  logic [W-1:0]      ret_q;
  logic              fault_q;

  logic [NREGS-1:0][W-1:0] regs;
  logic [W-1:0]      push_addr, push_word;
  logic              push_below;
  logic              sp_dec, sp_inc, sig_bad, last_push;
  logic [NREGS-1:0]  scrub_mask;
  logic              idle;

  assign idle      = (st == ST_IDLE);
  assign cmd_ready = idle;
  assign busy      = !idle && (st != ST_DONE);
  assign done      = (st == ST_DONE);
  assign fault     = done && fault_q;
  assign rd_data   = regs[rd_idx];

  assign sig_bad   = (k == 5'd0) && (rsp_data != SIG_WORD);
  assign sp_dec    = (st == ST_PUSH) && !push_below && mem_ready;
  assign sp_inc    = (st == ST_POP_WAIT) && rsp_valid && !sig_bad;
  assign last_push = (op_q == OP_CALL) ? (k == 5'(CALL_LAST)) : (k == 5'(FRAME_LAST));

  assign mem_valid = ((st == ST_PUSH) && !push_below) || (st == ST_POP_REQ);
  assign mem_we    = (st == ST_PUSH);
  assign mem_addr  = (st == ST_PUSH) ? push_addr : sp_out;
  assign mem_wdata = push_word;

  // word selection for the two push layouts
  always_comb begin
    push_word = '0;
    if (op_q == OP_CALL) begin
      push_word = (k == 5'd0) ? ret_q : (psr_out & PSR_KEEP);
    end else begin
      if (k == 5'd0)                       push_word = psr_out;
      else if (k == 5'd1)                  push_word = regs[LR_IDX];
      else if (k <= 5'd14)                 push_word = regs[IW'(5'd14 - k)];
      else                                 push_word = SIG_WORD;
    end
  end

  always_comb begin
    for (int i = 0; i < NREGS; i++)
      scrub_mask[i] = (i <= SCRUB_TOP) && ((op_q == OP_IRQ) || (i >= int'(nargs_q)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op_q <= OP_CALL; nargs_q <= '0; k <= '0;
      ret_q <= '0; fault_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q    <= op_e'(cmd_op);
          nargs_q <= (cmd_nargs > 3'(ARG_MAX)) ? 3'(ARG_MAX) : cmd_nargs;
          ret_q   <= cmd_ret_addr;
          k       <= '0;
          fault_q <= 1'b0;
          case (op_e'(cmd_op))
            OP_RET:    st <= ST_SCRUB;
            OP_RESUME: st <= ST_POP_REQ;
            default:   st <= ST_PUSH;
          endcase
        end
        ST_PUSH: begin
          if (push_below) begin
            fault_q <= 1'b1;
            st      <= ST_DONE;
          end else if (mem_ready) begin
            if (last_push) st <= ST_SCRUB;
            else           k  <= k + 5'd1;
          end
        end
        ST_SCRUB:    st <= ST_DONE;
        ST_POP_REQ:  if (mem_ready) st <= ST_POP_WAIT;
        ST_POP_WAIT: if (rsp_valid) begin
          if (sig_bad) begin
            fault_q <= 1'b1;
            st      <= ST_DONE;
          end else if (k == 5'(FRAME_LAST)) begin
            st <= ST_DONE;
          end else begin
            k  <= k + 5'd1;
            st <= ST_POP_REQ;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  wss_regbank #(.W(W), .NREGS(NREGS)) u_bank (
    .clk, .rst_n,
    .cpu_we       (cpu_we && idle),
    .cpu_idx,
    .cpu_wdata,
    .cpu_psr_we   (cpu_psr_we && idle),
    .cpu_psr_wdata,
    .scrub_en     (st == ST_SCRUB),
    .scrub_mask,
    .psr_clr      (st == ST_SCRUB),
    .lr_load      ((st == ST_SCRUB) && (op_q == OP_CALL)),
    .lr_value     (RET_MARK),
    .pop_we       (sp_inc && k >= 5'd1 && k <= 5'd14),
    .pop_idx      ((k == 5'd14) ? IW'(LR_IDX) : IW'(k - 5'd1)),
    .pop_psr_we   (sp_inc && k == 5'(FRAME_LAST)),
    .pop_data     (rsp_data),
    .regs_o       (regs),
    .psr_o        (psr_out)
  );

  wss_stack_ptr #(.W(W)) u_sp (
    .clk, .rst_n,
    .load       (sp_load && idle),
    .load_val   (sp_wdata),
    .dec        (sp_dec),
    .inc        (sp_inc),
    .limit      (stk_limit),
    .sp_o       (sp_out),
    .push_addr  (push_addr),
    .push_below (push_below)
  );

  // R1
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  // R1
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && cmd_ready);
  // R7
  push_in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_we) |-> (mem_addr >= stk_limit));
  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we));
  // R6
  ret_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> !mem_valid ##1 (done && !mem_valid));
endmodule

// File: tb/test_world_scrub_seq.sv
module test_world_scrub_seq;
  localparam int W = 32;
  localparam int NR = 16;
  localparam logic [31:0] SIG  = 32'h5A17_C3E9;
  localparam logic [31:0] MARK = 32'hFEFF_FFFE;
  localparam logic [31:0] KEEP = 32'h0000_01FF;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [2:0] cmd_nargs = 0;
  logic [31:0] cmd_ret_addr = 0;
  logic busy, done, fault;
  logic cpu_we = 0, cpu_psr_we = 0, sp_load = 0;
  logic [3:0] cpu_idx = 0, rd_idx = 0;
  logic [31:0] cpu_wdata = 0, cpu_psr_wdata = 0, sp_wdata = 0, stk_limit = 0;
  logic [31:0] rd_data, psr_out, sp_out;
  logic mem_valid, mem_ready = 1, mem_we, rsp_valid = 0;
  logic [31:0] mem_addr, mem_wdata, rsp_data = 0;

  always #5 clk = ~clk;

  world_scrub_seq #(.W(W), .NREGS(NR), .SIG_WORD(SIG), .RET_MARK(MARK), .PSR_KEEP(KEEP)) i_world_scrub_seq (
    .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_nargs, .cmd_ret_addr,
    .busy, .done, .fault, .cpu_we, .cpu_idx, .cpu_wdata, .cpu_psr_we, .cpu_psr_wdata,
    .sp_load, .sp_wdata, .stk_limit, .rd_idx, .rd_data, .psr_out, .sp_out,
    .mem_valid, .mem_ready, .mem_we, .mem_addr, .mem_wdata, .rsp_valid, .rsp_data);

  int compared = 0, mismatched = 0, cycles = 0;
  logic [31:0] m_regs [NR];
  logic [31:0] sv_regs [NR];
  logic [31:0] m_psr, sv_psr, m_sp, limit_v;
  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_wa[$], exp_wd[$], exp_ra[$];
  logic [15:0] lfsr = 16'hACE1;
  bit bp_on = 1, rsp_pend = 0;
  logic [31:0] rsp_addr;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural memory with throttled ready, compared on every clock
  always @(negedge clk) begin
    rsp_valid = rsp_pend;
    rsp_data  = mem.exists(rsp_addr) ? mem[rsp_addr] : 32'h0;
    rsp_pend  = 0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = bp_on ? (lfsr[0] | lfsr[2]) : 1'b1;
    if (mem_valid === 1'b1 && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        if (exp_wa.size() == 0) chk("R6", "unexpected write", mem_addr, 32'hx);
        else begin
          chk("R2/R4", "push addr", mem_addr, exp_wa.pop_front());
          chk("R2/R4", "push data", mem_wdata, exp_wd.pop_front());
        end
      end else begin
        if (exp_ra.size() == 0) chk("R9", "unexpected read", mem_addr, 32'hx);
        else chk("R8", "read addr", mem_addr, exp_ra.pop_front());
        rsp_pend = 1;
        rsp_addr = mem_addr;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check_state(input string req);
    for (int i = 0; i < NR; i++) begin
      rd_idx = 4'(i);
      #1;
      chk(req, $sformatf("r%0d", i), rd_data, m_regs[i]);
    end
    chk(req, "psr", psr_out, m_psr);
    chk(req, "sp", sp_out, m_sp);
  endtask

  task automatic reload(input logic [31:0] seed, input logic [31:0] sp_v);
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      cpu_we = 1; cpu_idx = 4'(i); cpu_wdata = seed + 32'h0101_0101 * i;
      m_regs[i] = cpu_wdata;
    end
    @(negedge clk);
    cpu_we = 0; cpu_psr_we = 1; cpu_psr_wdata = seed ^ 32'hF000_0EA5; m_psr = cpu_psr_wdata;
    sp_load = 1; sp_wdata = sp_v; m_sp = sp_v;
    @(negedge clk);
    cpu_psr_we = 0; sp_load = 0;
  endtask

  task automatic do_cmd(input logic [1:0] op, input int nargs, input logic [31:0] ra,
                        input bit poke, input bit sig_corrupt, input string req);
    int np = (nargs > 4) ? 4 : nargs;
    bit efault = 0;
    logic [31:0] esp = m_sp;
    logic [31:0] words[$];
    int guard = 0;
    if (op == 2'd0) words = '{ra, m_psr & KEEP};
    if (op == 2'd1) begin
      words.push_back(m_psr);
      words.push_back(m_regs[14]);
      for (int r = 12; r >= 0; r--) words.push_back(m_regs[r]);
      words.push_back(SIG);
      for (int i = 0; i < NR; i++) sv_regs[i] = m_regs[i];
      sv_psr = m_psr;
    end
    foreach (words[i]) begin
      if (esp < 4 || esp - 4 < limit_v) begin efault = 1; break; end
      esp = esp - 4;
      exp_wa.push_back(esp);
      exp_wd.push_back(words[i]);
    end
    if (op == 2'd3) begin
      exp_ra.push_back(esp);
      if (sig_corrupt) efault = 1;
      else begin
        for (int i = 1; i < 16; i++) exp_ra.push_back(esp + 4 * i);
        esp = esp + 64;
      end
    end
    if (!efault) begin
      case (op)
        2'd0: begin
          for (int r = np; r <= 12; r++) m_regs[r] = 0;
          m_psr = 0; m_regs[14] = MARK;
        end
        2'd1: begin for (int r = 0; r <= 12; r++) m_regs[r] = 0; m_psr = 0; end
        2'd2: begin for (int r = np; r <= 12; r++) m_regs[r] = 0; m_psr = 0; end
        default: begin
          for (int r = 0; r <= 12; r++) m_regs[r] = sv_regs[r];
          m_regs[14] = sv_regs[14]; m_psr = sv_psr;
        end
      endcase
    end
    m_sp = esp;
    @(negedge clk);
    chk("R1", "cmd_ready idle", {31'b0, cmd_ready}, 32'd1);
    cmd_valid = 1; cmd_op = op; cmd_nargs = 3'(nargs); cmd_ret_addr = ra;
    @(negedge clk);
    cmd_valid = 0;
    chk("R1", "busy after accept", {31'b0, busy}, 32'd1);
    chk("R1", "cmd_ready while busy", {31'b0, cmd_ready}, 32'd0);
    if (poke) begin
      cpu_we = 1; cpu_idx = 4'd14; cpu_wdata = 32'hDEAD_BEEF; sp_load = 1; sp_wdata = 32'h0;
      @(negedge clk);
      cpu_we = 0; sp_load = 0;
    end
    while (done !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
    chk(req, "fault", {31'b0, fault}, {31'b0, efault});
    chk("R1", "busy low with done", {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk("R1", "done pulse width", {31'b0, done}, 32'd0);
    chk("R1", "ready after done", {31'b0, cmd_ready}, 32'd1);
    chk(req, "pending pushes", exp_wa.size(), 0);
    chk(req, "pending reads", exp_ra.size(), 0);
    exp_wa.delete(); exp_wd.delete(); exp_ra.delete();
    check_state(req);
  endtask

  initial begin
    limit_v = 32'h0000_1000;
    stk_limit = limit_v;
    for (int i = 0; i < NR; i++) m_regs[i] = 0;
    m_psr = 0; m_sp = 0;
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", {31'b0, cmd_ready}, 32'd1);
    chk("R1", "reset busy", {31'b0, busy}, 32'd0);
    chk("R1", "reset done", {31'b0, done}, 32'd0);
    chk("R10", "reset mem_valid", {31'b0, mem_valid}, 32'd0);
    check_state("R1");
    rst_n = 1;

    reload(32'h1000_0001, 32'h0000_2000);
    do_cmd(2'd0, 2, 32'h8000_1235, 0, 0, "R2 R3");       // call, two args
    reload(32'h2000_0003, 32'h0000_2400);
    do_cmd(2'd0, 7, 32'h8000_4001, 0, 0, "R3");          // clamp to 4
    reload(32'h3000_0005, 32'h0000_2400);
    do_cmd(2'd2, 1, 32'h0, 0, 0, "R6");                  // return, one result
    reload(32'h4000_0007, 32'h0000_2800);
    do_cmd(2'd1, 0, 32'h0, 1, 0, "R4 R5 R11");           // interrupt, with ignored pokes
    do_cmd(2'd3, 0, 32'h0, 0, 0, "R8");                  // resume restores
    reload(32'h5000_0009, 32'h0000_3000);
    do_cmd(2'd1, 0, 32'h0, 0, 0, "R4 R5");
    mem[m_sp] = SIG ^ 32'h0000_0100;                     // corrupt signature
    do_cmd(2'd3, 0, 32'h0, 0, 1, "R9");
    bp_on = 0;
    reload(32'h6000_000B, 32'h0000_1004);
    do_cmd(2'd0, 3, 32'h8000_7777, 0, 0, "R7");          // second push crosses limit
    reload(32'h7000_000D, 32'h0000_1010);
    do_cmd(2'd1, 0, 32'h0, 0, 0, "R7");                  // frame crosses limit
    reload(32'h7100_000F, 32'h0000_1008);
    do_cmd(2'd0, 1, 32'h8000_0F0F, 0, 0, "R2");          // lands exactly on limit
    bp_on = 1;
    reload(32'h0000_0000, 32'h0000_0002);
    do_cmd(2'd0, 0, 32'h1, 0, 0, "R7");                  // sp below one word
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule